// File: doc/BRIEF.md
# Descriptor Ring Walker

This block steps through a list of 16-byte transfer descriptors kept in system memory and hands every buffer it finds to a separate data mover. Software supplies a base address, a word skip, a direction flag and an enable. Descriptors are read one word per access over a simple word-wide memory port. The ownership flag is tested as soon as the first word arrives. Each non-empty buffer is offered to the mover as an address and byte-length pair over a valid/ready handshake, and the block waits for the mover's completion pulse before it goes on.

After both buffers of a descriptor are finished, the block writes the first descriptor word back. Ownership is cleared in that write and any card error is recorded. It then works out where the next descriptor is. The next descriptor is either the one named by the link pointer, the one after a programmable gap of words, or the base address again when the ring ends. A descriptor that software has not handed over stops the walk. The block then stays suspended until software writes the poll-demand strobe. Sticky status flags record completions, suspension, card errors and bus faults, and software clears them by writing 1 to them.

Top module: `desc_walker`

## Requirements
- R1: After `rst_n` is held low for a clock edge, `sts_word` reads 0, `mem_req` is low and `xfer_valid` is low.
- R2: While `cfg_enable` is low, the block issues no descriptor read and the state field `sts_word[16:13]` stays at 0 (idle).
- R3: A descriptor at address A is read as words at A, A+4, A+8 and A+12. If bit 31 of word 0 is clear, status bit 4 (descriptor unavailable) sets, the state field becomes 7 (suspended), and no further memory access is made until a poll demand arrives.
- R4: Buffer 1 uses word 2 as its address and word 1 bits [12:0] as its length. Buffer 2 uses word 3 as its address and word 1 bits [25:13] as its length. Buffer 1 is offered before buffer 2. A buffer whose length is zero is never offered. When both lengths are zero, the descriptor goes straight to write-back.
- R5: When word 0 bit 4 (linked) is set, buffer 2 is never offered and the next descriptor is read from the address in word 3.
- R6: When bit 4 is clear, the next descriptor starts at A + 16 + 4*`cfg_skip`. When word 0 bit 5 (ring end) is set, the next descriptor starts at `cfg_base` instead. The link bit takes priority over the ring-end bit.
- R7: Before the next descriptor is read, word 0 is written back to A. In the written value bit 31 is 0, bit 30 is 1 exactly when the mover flagged a card error on either buffer, and all other bits are unchanged.
- R8: When the write-back of a descriptor with bit 2 (last) set and bit 1 (quiet) clear is accepted, status bit 0 sets if `cfg_tx_dir` is 1 and status bit 1 sets otherwise. Status bit 8 reads as the OR of bits 0 and 1. Status bit 5 sets when the written-back descriptor carried a card error.
- R9: A cycle with `sts_clr_we` high clears every status flag whose `sts_clr_mask` bit is 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: A `poll_demand` pulse while suspended makes the block read the same descriptor address again and continue the walk from there.
- R11: A memory access accepted with `mem_err` high sets status bit 2 and moves the state field to 8 (halted). After that the block makes no further memory access or transfer offer.
- R12: A `cfg_sw_reset` pulse returns the state field to 0 and clears every status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Allows descriptor fetching |
| cfg_sw_reset | input | 1 | One-cycle pulse that returns the engine to idle and clears status |
| cfg_base | input | ADDR_W | Address of the first descriptor and ring wrap target |
| cfg_skip | input | SKIP_W | Words left unused between sequential descriptors |
| cfg_tx_dir | input | 1 | 1: completions count as transmit, 0: as receive |
| poll_demand | input | 1 | One-cycle pulse that resumes a suspended walk |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for status flags |
| sts_clr_mask | input | 32 | Flags to clear, aligned with `sts_word` |
| sts_word | output | 32 | Status flags and state field [16:13] |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write-back, 0: read |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Bus error on the accepted access |
| xfer_valid | output | 1 | Buffer offer to the mover |
| xfer_ready | input | 1 | Mover takes the offer |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | LEN_W | Buffer length in bytes |
| xfer_done | input | 1 | Pulse: the accepted buffer is finished |
| xfer_card_err | input | 1 | Card error, sampled with `xfer_done` |

## Verification
A software clear of a status flag can land on the same clock edge as the write-back that sets that flag. The bench provokes this with its memory model. In the cycle where the model accepts the write-back, it also raises `sts_clr_we` with the transmit-done bit in the mask. The transmit-done flag must read 1 afterwards, because a set wins over a clear. A later clear without a competing set must then drop only that flag and leave descriptor-unavailable standing.

// File: rtl/dwalk_pkg.sv
// Shared definitions for the descriptor walker: state codes as they appear
// in the status word, and bit positions inside descriptor word 0.
// Assumes a descriptor of four 32-bit words.
package dwalk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_FETCH   = 4'd1,
        ST_BUF1    = 4'd2,
        ST_WAIT1   = 4'd3,
        ST_BUF2    = 4'd4,
        ST_WAIT2   = 4'd5,
        ST_WBACK   = 4'd6,
        ST_SUSPEND = 4'd7,
        ST_FATAL   = 4'd8
    } walk_state_e;

    localparam int unsigned DESC_BYTES = 16;
    localparam int unsigned W0_QUIET   = 1;
    localparam int unsigned W0_LAST    = 2;
    localparam int unsigned W0_LINK    = 4;
    localparam int unsigned W0_RINGEND = 5;
    localparam int unsigned W0_CERR    = 30;
    localparam int unsigned W0_OWN     = 31;

    localparam int unsigned STS_FSM_LO = 13;
    localparam int unsigned STS_NIS    = 8;

endpackage

// File: rtl/dwalk_next_addr.sv
// Next-descriptor address selection.
// Assumes: the link bit takes priority over the ring-end bit; the
// sequential step is one descriptor plus skip_words 32-bit words.
module dwalk_next_addr #(
    parameter int ADDR_W = 32,
    parameter int SKIP_W = 5
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic [SKIP_W-1:0] skip_words,
    input  logic              linked,
    input  logic              ring_end,
    output logic [ADDR_W-1:0] next_addr
);
    import dwalk_pkg::*;

    logic [ADDR_W-1:0] seq_addr;

    // Sequential successor: past this descriptor plus the skip gap.
    always_comb begin
        seq_addr = cur_addr + ADDR_W'(DESC_BYTES) + (ADDR_W'(skip_words) << 2);
    end

    // Pick link pointer, ring wrap or sequential successor.
    always_comb begin
        if (linked)        next_addr = link_addr;
        else if (ring_end) next_addr = base_addr;
        else               next_addr = seq_addr;
    end
endmodule

// File: rtl/dwalk_status.sv
// Sticky status flags with write-one-to-clear, packed with the engine state.
// Assumes: a set and a clear in the same cycle leave the flag set; the
// soft clear outranks both. Summary bit is the OR of both completion flags.
module dwalk_status #(
    parameter int FSM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             set_tx,
    input  logic             set_rx,
    input  logic             set_fbe,
    input  logic             set_du,
    input  logic             set_ces,
    input  logic             clr_we,
    input  logic [31:0]      clr_mask,
    input  logic [FSM_W-1:0] fsm_code,
    output logic [31:0]      sts_word
);
    import dwalk_pkg::*;

    localparam int NFLAG = 5;
    localparam int FLAG_POS [NFLAG] = '{0, 1, 2, 4, 5};

    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    logic             unused_mask;

    assign set_vec     = {set_ces, set_du, set_fbe, set_rx, set_tx};
    assign unused_mask = ^{clr_mask[31:6], clr_mask[3]};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic bit_q;
        // One sticky flag: set wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr)                  bit_q <= 1'b0;
            else if (set_vec[g])                     bit_q <= 1'b1;
            else if (clr_we && clr_mask[FLAG_POS[g]]) bit_q <= 1'b0;
        end
        assign flags[g] = bit_q;
    end

    // Assemble the readable word from flags, summary and state.
    always_comb begin
        sts_word = '0;
        for (int i = 0; i < NFLAG; i++) sts_word[FLAG_POS[i]] = flags[i];
        sts_word[STS_NIS] = flags[0] | flags[1];
        sts_word[STS_FSM_LO +: FSM_W] = fsm_code;
    end
endmodule

// File: rtl/desc_walker.sv
// Descriptor walker top: fetches 4-word descriptors one word per access,
// checks ownership, offers up to two buffers to a data mover, writes word 0
// back with ownership returned, then moves to the next descriptor.
// Assumes: memory port holds a request until mem_ack; read data and error
// are valid in the ack cycle; the mover pulses xfer_done once per accepted
// buffer; cfg_sw_reset and poll_demand are single-cycle strobes.
module desc_walker #(
    parameter int ADDR_W = 32,
    parameter int SKIP_W = 5,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_sw_reset,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic              cfg_tx_dir,
    input  logic              poll_demand,
    input  logic              sts_clr_we,
    input  logic [31:0]       sts_clr_mask,
    output logic [31:0]       sts_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    input  logic              xfer_card_err
);
    import dwalk_pkg::*;

    localparam int SIZES_W = 2 * LEN_W;

    walk_state_e        state;
    logic [1:0]         widx;
    logic [ADDR_W-1:0]  cur_addr;
    logic [31:0]        dw0;
    logic [SIZES_W-1:0] dw1;
    logic [ADDR_W-1:0]  dw2;
    logic [ADDR_W-1:0]  dw3;
    logic               card_err_q;

    logic [LEN_W-1:0]   size1, size2;
    logic               buf2_used, fetch_go, acc;
    logic               set_tx, set_rx, set_fbe, set_du, set_ces;
    logic               wb_ok, completes;
    logic [ADDR_W-1:0]  next_addr;

    // Decode descriptor fields and handshake conditions.
    always_comb begin
        size1     = dw1[LEN_W-1:0];
        size2     = dw1[SIZES_W-1:LEN_W];
        buf2_used = !dw0[W0_LINK] && (size2 != '0);
        fetch_go  = (state == ST_FETCH) && ((widx != 2'd0) || cfg_enable);
        acc       = mem_req && mem_ack;
    end

    // Drive the memory port.
    always_comb begin
        mem_req   = fetch_go || (state == ST_WBACK);
        mem_we    = (state == ST_WBACK);
        mem_addr  = (state == ST_WBACK) ? cur_addr
                                        : cur_addr + ADDR_W'({widx, 2'b00});
        mem_wdata = {1'b0, card_err_q, dw0[W0_CERR-1:0]};
    end

    // Drive the buffer offer to the mover.
    always_comb begin
        xfer_valid = ((state == ST_BUF1) && (size1 != '0)) ||
                     ((state == ST_BUF2) && buf2_used);
        xfer_addr  = (state == ST_BUF2) ? dw3 : dw2;
        xfer_len   = (state == ST_BUF2) ? size2 : size1;
    end

    // Status set events.
    always_comb begin
        set_fbe   = acc && mem_err;
        set_du    = acc && !mem_err && (state == ST_FETCH) &&
                    (widx == 2'd0) && !mem_rdata[W0_OWN];
        wb_ok     = acc && !mem_err && (state == ST_WBACK);
        completes = wb_ok && dw0[W0_LAST] && !dw0[W0_QUIET];
        set_tx    = completes && cfg_tx_dir;
        set_rx    = completes && !cfg_tx_dir;
        set_ces   = wb_ok && card_err_q;
    end

    dwalk_next_addr #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_next (
        .cur_addr   (cur_addr),
        .base_addr  (cfg_base),
        .link_addr  (dw3),
        .skip_words (cfg_skip),
        .linked     (dw0[W0_LINK]),
        .ring_end   (dw0[W0_RINGEND]),
        .next_addr  (next_addr)
    );

    // Walk sequencer: fetch, offer buffers, write back, advance or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_sw_reset) begin
            state      <= ST_IDLE;
            widx       <= 2'd0;
            cur_addr   <= '0;
            dw0        <= '0;
            dw1        <= '0;
            dw2        <= '0;
            dw3        <= '0;
            card_err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cfg_enable) begin
                    cur_addr <= cfg_base;
                    widx     <= 2'd0;
                    state    <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (!fetch_go) begin
                        state <= ST_IDLE;
                    end else if (acc) begin
                        if (mem_err) begin
                            state <= ST_FATAL;
                        end else begin
                            case (widx)
                                2'd0:    dw0 <= mem_rdata;
                                2'd1:    dw1 <= mem_rdata[SIZES_W-1:0];
                                2'd2:    dw2 <= mem_rdata[ADDR_W-1:0];
                                default: dw3 <= mem_rdata[ADDR_W-1:0];
                            endcase
                            if ((widx == 2'd0) && !mem_rdata[W0_OWN]) begin
                                state <= ST_SUSPEND;
                            end else if (widx == 2'd3) begin
                                widx       <= 2'd0;
                                card_err_q <= 1'b0;
                                state      <= ST_BUF1;
                            end else begin
                                widx <= widx + 2'd1;
                            end
                        end
                    end
                end
                ST_BUF1: begin
                    if (size1 == '0)     state <= ST_BUF2;
                    else if (xfer_ready) state <= ST_WAIT1;
                end
                ST_WAIT1: if (xfer_done) begin
                    card_err_q <= card_err_q | xfer_card_err;
                    state      <= ST_BUF2;
                end
                ST_BUF2: begin
                    if (!buf2_used)      state <= ST_WBACK;
                    else if (xfer_ready) state <= ST_WAIT2;
                end
                ST_WAIT2: if (xfer_done) begin
                    card_err_q <= card_err_q | xfer_card_err;
                    state      <= ST_WBACK;
                end
                ST_WBACK: if (acc) begin
                    if (mem_err) begin
                        state <= ST_FATAL;
                    end else begin
                        cur_addr <= next_addr;
                        state    <= ST_FETCH;
                    end
                end
                ST_SUSPEND: if (poll_demand) state <= ST_FETCH;
                ST_FATAL:   state <= ST_FATAL;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    dwalk_status #(.FSM_W(4)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (cfg_sw_reset),
        .set_tx   (set_tx),
        .set_rx   (set_rx),
        .set_fbe  (set_fbe),
        .set_du   (set_du),
        .set_ces  (set_ces),
        .clr_we   (sts_clr_we),
        .clr_mask (sts_clr_mask),
        .fsm_code (state),
        .sts_word (sts_word)
    );
endmodule

// File: rtl/desc_walker_chk.sv
// Protocol checker for desc_walker, attached by bind. Observes ports only.
// Assumes the synchronous active-low reset of the block it watches.
module desc_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_sw_reset,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wdata_own,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic [3:0]        fsm_code,
    input logic [5:0]        flag_bits
);
    // R4: an offer stays unchanged until the mover takes it
    a_r4_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

    // R4: zero-length buffers are never offered
    a_r4_no_empty_offer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_len != '0);

    // R3: a memory request stays unchanged until acknowledged
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3: a suspended engine leaves memory alone
    a_r3_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_code == 4'd7 |-> !mem_req);

    // R7: every write-back returns ownership
    a_r7_wb_disowns: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !wdata_own);

    // R11: a halted engine neither accesses memory nor offers buffers
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_code == 4'd8 |-> !mem_req && !xfer_valid);

    // R2: idle means no memory traffic
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_code == 4'd0 |-> !mem_req);

    // R12: a soft reset leaves the engine idle with clean flags
    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_reset |=> fsm_code == 4'd0 && flag_bits == 6'd0);
endmodule

bind desc_walker desc_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sw_reset (cfg_sw_reset),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .wdata_own    (mem_wdata[31]),
    .xfer_valid   (xfer_valid),
    .xfer_ready   (xfer_ready),
    .xfer_addr    (xfer_addr),
    .xfer_len     (xfer_len),
    .fsm_code     (sts_word[16:13]),
    .flag_bits    (sts_word[5:0])
);

// File: tb/desc_walker_tb_top.sv
// Bench for desc_walker: a behavioural memory and mover act on the falling
// edge; a vector table drives single-descriptor runs, then directed tests.
module desc_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable, cfg_sw_reset, cfg_tx_dir, poll_demand;
    logic [31:0] cfg_base;
    logic [4:0]  cfg_skip;
    logic        sts_clr_we = 1'b0;
    logic [31:0] sts_clr_mask = '0;
    logic [31:0] sts_word;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        xfer_valid;
    logic        xfer_ready;
    logic [31:0] xfer_addr;
    logic [12:0] xfer_len;
    logic        xfer_done = 1'b0, xfer_card_err = 1'b0;

    assign xfer_ready = 1'b1;

    always #10 clk = ~clk;

    desc_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sw_reset(cfg_sw_reset),
        .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_tx_dir(cfg_tx_dir),
        .poll_demand(poll_demand), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .sts_word(sts_word), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_card_err(xfer_card_err)
    );

    // Models, written only by the falling-edge process
    logic [31:0] mem [0:255];
    int          mv_delay = 0, xfer_n = 0, xfer_sum = 0, rd_cnt = 0;
    logic [31:0] last_rd = '0;
    logic [31:0] xlog [0:63];
    int          poke_seen = 0, wipe_seen = 0, clr_seen = 0;
    // Requests from the test sequence
    int          poke_cnt = 0, wipe_cnt = 0, clr_cnt = 0;
    logic [7:0]  poke_a = '0;
    logic [31:0] poke_d = '0, clr_mask_v = '0;
    logic        clr_on_wb = 1'b0, err_en = 1'b0, inj_card_err = 1'b0;
    logic [31:0] err_addr = '0;

    int n_chk = 0, n_fail = 0;

    // Falling edge: memory, mover and status-clear drivers
    always @(negedge clk) begin
        if (wipe_cnt != wipe_seen) begin
            for (int i = 0; i < 256; i++) mem[i] = '0;
            wipe_seen = wipe_cnt;
        end
        if (poke_cnt != poke_seen) begin
            mem[poke_a] = poke_d;
            poke_seen = poke_cnt;
        end
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        sts_clr_we = 1'b0;
        if (clr_cnt != clr_seen) begin
            sts_clr_we = 1'b1; sts_clr_mask = clr_mask_v; clr_seen = clr_cnt;
        end else if (clr_on_wb && mem_req === 1'b1 && mem_we === 1'b1) begin
            sts_clr_we = 1'b1; sts_clr_mask = 32'h1;
        end
        if (mem_req === 1'b1) begin
            mem_ack = 1'b1;
            mem_err = err_en && (mem_addr == err_addr);
            if (mem_we) begin
                if (!mem_err) mem[mem_addr[9:2]] = mem_wdata;
            end else begin
                mem_rdata = mem[mem_addr[9:2]];
                last_rd = mem_addr;
                rd_cnt++;
            end
        end
        xfer_done = 1'b0; xfer_card_err = 1'b0;
        if (mv_delay > 0) begin
            mv_delay--;
            if (mv_delay == 0) begin xfer_done = 1'b1; xfer_card_err = inj_card_err; end
        end else if (xfer_valid === 1'b1) begin
            xlog[xfer_n[5:0]] = xfer_addr;
            xfer_sum += int'(xfer_len);
            xfer_n++;
            mv_delay = 2;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        poke_a = a[9:2]; poke_d = d; poke_cnt++;
        tick(1);
    endtask

    task automatic wipe();
        wipe_cnt++;
        tick(1);
    endtask

    task automatic clear_sts(input logic [31:0] m);
        clr_mask_v = m; clr_cnt++;
        tick(2);
    endtask

    task automatic soft_reset();
        cfg_enable = 1'b0; cfg_sw_reset = 1'b1;
        tick(1);
        cfg_sw_reset = 1'b0;
    endtask

    task automatic poll();
        poll_demand = 1'b1;
        tick(1);
        poll_demand = 1'b0;
    endtask

    task automatic wait_du(input int max);
        for (int k = 0; k < max; k++) begin
            if (sts_word[4]) break;
            tick(1);
        end
    endtask

    typedef struct packed {
        logic [7:0]  flags;
        logic [12:0] s1;
        logic [12:0] s2;
        logic        tx;
        logic        err;
        logic [3:0]  n;
        logic [15:0] len;
        logic [15:0] a0;
        logic [8:0]  sts;
    } vec_t;

    // flags: bit1 quiet, bit2 last, bit3 first, bit4 linked, bit5 ring end
    localparam vec_t VECS [5] = '{
        '{8'h0C, 13'd100,  13'd40, 1'b1, 1'b0, 4'd2, 16'd140,  16'h1000, 9'h111},
        '{8'h06, 13'd8,    13'd0,  1'b0, 1'b0, 4'd1, 16'd8,    16'h1000, 9'h010},
        '{8'h08, 13'd0,    13'd12, 1'b0, 1'b0, 4'd1, 16'd12,   16'h2000, 9'h010},
        '{8'h04, 13'd0,    13'd0,  1'b0, 1'b0, 4'd0, 16'd0,    16'h0000, 9'h112},
        '{8'h14, 13'd4096, 13'd77, 1'b1, 1'b1, 4'd1, 16'd4096, 16'h1000, 9'h131}
    };

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int n0, s0, r0;
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_sw_reset = 1'b0; cfg_tx_dir = 1'b0;
        poll_demand = 1'b0; cfg_base = 32'h40; cfg_skip = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1", "status after reset", sts_word, 32'h0);
        check("R1", "mem_req after reset", {31'b0, mem_req}, 32'h0);
        check("R1", "xfer_valid after reset", {31'b0, xfer_valid}, 32'h0);

        // Vector table: one descriptor per run, following slot left empty
        foreach (VECS[v]) begin
            soft_reset();
            wipe();
            poke(32'h40, 32'h8000_0000 | 32'(VECS[v].flags));
            poke(32'h44, {6'b0, VECS[v].s2, VECS[v].s1});
            poke(32'h48, 32'h1000);
            poke(32'h4C, VECS[v].flags[4] ? 32'h200 : 32'h2000);
            cfg_tx_dir = VECS[v].tx; inj_card_err = VECS[v].err;
            n0 = xfer_n; s0 = xfer_sum;
            cfg_enable = 1'b1;
            wait_du(300);
            check("R4", $sformatf("v%0d offers", v), 32'(xfer_n - n0), 32'(VECS[v].n));
            check("R4", $sformatf("v%0d total length", v), 32'(xfer_sum - s0), 32'(VECS[v].len));
            if (VECS[v].n != 0)
                check("R4", $sformatf("v%0d first address", v), xlog[n0[5:0]], 32'(VECS[v].a0));
            check("R8", $sformatf("v%0d status flags", v), {23'b0, sts_word[8:0]}, 32'(VECS[v].sts));
            check("R7", $sformatf("v%0d written word 0", v), mem[16],
                  32'(VECS[v].flags) | (32'(VECS[v].err) << 30));
            check(VECS[v].flags[4] ? "R5" : "R6", $sformatf("v%0d next fetch", v), last_rd,
                  VECS[v].flags[4] ? 32'h200 : 32'h50);
            check("R3", $sformatf("v%0d suspended state", v), 32'(sts_word[16:13]), 32'd7);
        end
        inj_card_err = 1'b0;

        // R2: disabled engine never fetches
        soft_reset();
        wipe();
        poke(32'h40, 32'h8000_0004);
        r0 = rd_cnt;
        tick(20);
        check("R2", "reads while disabled", 32'(rd_cnt - r0), 32'd0);
        check("R2", "state while disabled", 32'(sts_word[16:13]), 32'd0);

        // R6: skip gap then ring wrap to base
        soft_reset();
        wipe();
        cfg_skip = 5'd3; cfg_tx_dir = 1'b0;
        poke(32'h40, 32'h8000_0000);
        poke(32'h44, 32'd4);
        poke(32'h48, 32'h1100);
        poke(32'h5C, 32'h8000_0020);
        poke(32'h60, 32'd8);
        poke(32'h64, 32'h1200);
        n0 = xfer_n;
        cfg_enable = 1'b1;
        wait_du(300);
        check("R6", "offers over skip and wrap", 32'(xfer_n - n0), 32'd2);
        check("R6", "second descriptor after skip", xlog[6'(n0 + 1)], 32'h1200);
        check("R6", "ring wraps to base", last_rd, 32'h40);
        check("R8", "no completion without last", 32'(sts_word[1:0]), 32'd0);

        // R3 / R9 / R10: stay suspended, clear flag, resume on poll
        r0 = rd_cnt;
        tick(10);
        check("R3", "no reads while suspended", 32'(rd_cnt - r0), 32'd0);
        clear_sts(32'h10);
        check("R9", "unavailable flag cleared", 32'(sts_word[4]), 32'd0);
        poke(32'h40, mem[16] | 32'h8000_0000);
        tick(5);
        check("R10", "no reads before poll", 32'(rd_cnt - r0), 32'd0);
        n0 = xfer_n;
        poll();
        wait_du(300);
        check("R10", "offers after poll", 32'(xfer_n - n0), 32'd1);
        check("R10", "refetch continued to next", last_rd, 32'h5C);
        check("R10", "unavailable again", 32'(sts_word[4]), 32'd1);

        // R9: clear lands in the write-back cycle; set wins
        soft_reset();
        wipe();
        cfg_skip = '0; cfg_tx_dir = 1'b1;
        poke(32'h40, 32'h8000_0004);
        poke(32'h44, 32'd16);
        poke(32'h48, 32'h1300);
        clr_on_wb = 1'b1;
        cfg_enable = 1'b1;
        wait_du(300);
        clr_on_wb = 1'b0;
        check("R9", "set wins over same-cycle clear", 32'(sts_word[0]), 32'd1);
        check("R8", "summary follows transmit flag", 32'(sts_word[8]), 32'd1);
        clear_sts(32'h1);
        check("R9", "transmit flag cleared", 32'(sts_word[0]), 32'd0);
        check("R8", "summary drops with flag", 32'(sts_word[8]), 32'd0);
        check("R9", "unmasked flag kept", 32'(sts_word[4]), 32'd1);

        // R11 / R12: bus error halts; soft reset recovers
        soft_reset();
        wipe();
        poke(32'h40, 32'h8000_0004);
        poke(32'h44, 32'd16);
        err_en = 1'b1; err_addr = 32'h44;
        n0 = xfer_n;
        cfg_enable = 1'b1;
        tick(10);
        check("R11", "bus error flag", 32'(sts_word[2]), 32'd1);
        check("R11", "halted state", 32'(sts_word[16:13]), 32'd8);
        r0 = rd_cnt;
        tick(10);
        check("R11", "no access after halt", 32'(rd_cnt - r0), 32'd0);
        check("R11", "no offers after halt", 32'(xfer_n - n0), 32'd0);
        err_en = 1'b0;
        soft_reset();
        check("R12", "status after soft reset", sts_word, 32'h0);

        report();
        $finish;
    end
endmodule